// File: doc/BRIEF.md
# PWM Fault Shutdown and Restart Guard

This block sits between a PWM waveform generator and four output pins, A, B, C and D. It watches up to three fault sources: two active-high comparator outputs and one active-low external fault pin. When an enabled source reports a fault, the four pins are forced into programmed safe levels at once, through logic with no register in the path. A sticky shutdown flag records the event. The flag keeps the pins safe and is cleared in one of two ways. Firmware can clear it with a write once the fault has gone. If auto-restart is enabled, hardware clears it by itself.

The pins never return to the PWM waveform in the middle of a period. On each period-start pulse the block latches a run or hold decision for the whole coming period. Raw PWM values pass to the pins only while that decision is "run", the flag is clear and no enabled fault is present. The pins are paired A/C and B/D. Each pair has its own safe mode: drive low, drive high, or release the pins by lowering their output enables.

Top module: `pwm_fault_guard`

## Requirements
- R1: `src_sel_i` bit 0 enables comparator 1, bit 1 enables comparator 2 and bit 2 enables the external pin (a fault when `ext_flt_n_i` is 0). A source that is not enabled neither forces the pins nor sets the flag. With `src_sel_i` = 000, auto-shutdown is off.
- R2: While an enabled fault is present at the inputs, the pins show their safe state in the same cycle, before any clock edge.
- R3: Safe mode per pair, with `safe_ac_i` for A/C (bits 0 and 2) and `safe_bd_i` for B/D (bits 1 and 3): 00 drives 0 with the enable at 1, 10 drives 1 with the enable at 1, and 01 or 11 gives an enable of 0 with a pin value of 0. Outside shutdown all enables are 1.
- R4: An enabled comparator fault sets `sd_flag_o` on the next clock edge. An external-pin fault passes through a two-stage synchronizer first, so it sets the flag on the third edge after the pin goes low.
- R5: While `sd_flag_o` is 1, the pins hold their safe state. With auto-restart off, the flag stays set until a firmware write of 0 (`flag_wr_i`=1, `flag_wdata_i`=0) arrives with no synchronized fault present.
- R6: A firmware write to the flag has no effect while a synchronized enabled fault is present.
- R7: With `auto_restart_i`=1, the flag clears on the first edge at which no synchronized enabled fault is present.
- R8: The flag value seen at a period start decides the period. If the flag was set at that start, the pins stay safe for the whole period, even if the flag clears during it. After the flag clears, raw PWM returns only after the next period-start edge.
- R9: If a fault is present in the same cycle as a firmware clear, the fault wins and the flag stays set.
- R10: After reset, `sd_flag_o` is 0 and the pins hold their safe state until the first period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp1_flt_i | input | 1 | Comparator 1 fault, active high |
| cmp2_flt_i | input | 1 | Comparator 2 fault, active high |
| ext_flt_n_i | input | 1 | External fault pin, active low, asynchronous |
| period_start_i | input | 1 | One-cycle pulse at the start of each PWM period |
| pwm_raw_i | input | 4 | Raw PWM values for A, B, C, D (bits 0 to 3) |
| src_sel_i | input | 3 | Fault source enables |
| safe_ac_i | input | 2 | Safe mode for pins A and C |
| safe_bd_i | input | 2 | Safe mode for pins B and D |
| auto_restart_i | input | 1 | Lets hardware clear the flag when the fault is gone |
| flag_wr_i | input | 1 | Firmware write strobe for the flag |
| flag_wdata_i | input | 1 | Value written to the flag |
| pin_o | output | 4 | Pin values A, B, C, D |
| pin_oe_o | output | 4 | Output enables, 0 means released |
| sd_flag_o | output | 1 | Shutdown-active flag |

## Verification
Two pairs of actions can fall in the same cycle. The first is a fault arriving with a firmware clear. The bench sets a flag, drops the fault, then raises a comparator fault in the same cycle as a write of 0, and expects the flag still set on the next edge. The second is a period-start pulse falling in a period where the flag is set. The bench sets the flag, gives a period start, clears the flag during that period, and expects the pins to stay safe until the following period start. A long pseudo-random run then mixes faults, writes, auto-restart and period pulses, and compares the pins and flag against a behavioural model on every cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned PAIR_COUNT = 2;

  typedef logic [1:0] safe_mode_t;

  // 00 low, 10 high, x1 released
  function automatic logic safe_level(safe_mode_t m);
    return (m == 2'b10);
  endfunction

  function automatic logic safe_drives(safe_mode_t m);
    return !m[0];
  endfunction
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_fault_sel.sv
module pfg_fault_sel #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] sel,
  input  logic [NUM_SRC-1:0] raw_active,
  input  logic [NUM_SRC-1:0] sync_active,
  output logic               fault_now,
  output logic               fault_seen
);
  assign fault_now  = |(sel & raw_active);
  assign fault_seen = |(sel & sync_active);
endmodule

// File: rtl/pfg_flag_ctrl.sv
module pfg_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic fault_seen,
  input  logic auto_restart,
  input  logic wr,
  input  logic wdata,
  input  logic period_start,
  output logic flag_q,
  output logic run_q
);
  logic flag_d;
  logic run_d;

  always_comb begin
    if (fault_seen)        flag_d = 1'b1;
    else if (auto_restart) flag_d = 1'b0;
    else if (wr)           flag_d = wdata;
    else                   flag_d = flag_q;
  end

  always_comb begin
    if (period_start) run_d = !flag_q;
    else if (flag_q)  run_d = 1'b0;
    else              run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/pfg_pin_drive.sv
module pfg_pin_drive
  import pfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0] raw,
  input  logic                pass,
  input  safe_mode_t          mode_ac,
  input  safe_mode_t          mode_bd,
  output logic [NUM_PINS-1:0] pin,
  output logic [NUM_PINS-1:0] oe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned PAIR = i % PAIR_COUNT;
    safe_mode_t m;
    assign m      = (PAIR == 0) ? mode_ac : mode_bd;
    assign pin[i] = pass ? raw[i] : safe_level(m);
    assign oe[i]  = pass ? 1'b1   : safe_drives(m);
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_PINS    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp1_flt_i,
  input  logic                cmp2_flt_i,
  input  logic                ext_flt_n_i,
  input  logic                period_start_i,
  input  logic [NUM_PINS-1:0] pwm_raw_i,
  input  logic [2:0]          src_sel_i,
  input  logic [1:0]          safe_ac_i,
  input  logic [1:0]          safe_bd_i,
  input  logic                auto_restart_i,
  input  logic                flag_wr_i,
  input  logic                flag_wdata_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                sd_flag_o
);
  localparam int unsigned NUM_SRC = 3;

  logic               ext_sync;
  logic [NUM_SRC-1:0] raw_active;
  logic [NUM_SRC-1:0] sync_active;
  logic               fault_now;
  logic               fault_seen;
  logic               flag_q;
  logic               run_q;
  logic               pass;

  pfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ext_sync (
    .clk (clk),
    .rst (rst),
    .d   (!ext_flt_n_i),
    .q   (ext_sync)
  );

  assign raw_active  = {!ext_flt_n_i, cmp2_flt_i, cmp1_flt_i};
  assign sync_active = {ext_sync,     cmp2_flt_i, cmp1_flt_i};

  pfg_fault_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .sel         (src_sel_i),
    .raw_active  (raw_active),
    .sync_active (sync_active),
    .fault_now   (fault_now),
    .fault_seen  (fault_seen)
  );

  pfg_flag_ctrl u_flag (
    .clk          (clk),
    .rst          (rst),
    .fault_seen   (fault_seen),
    .auto_restart (auto_restart_i),
    .wr           (flag_wr_i),
    .wdata        (flag_wdata_i),
    .period_start (period_start_i),
    .flag_q       (flag_q),
    .run_q        (run_q)
  );

  assign pass = run_q && !flag_q && !fault_now;

  pfg_pin_drive #(.NUM_PINS(NUM_PINS)) u_pins (
    .raw     (pwm_raw_i),
    .pass    (pass),
    .mode_ac (safe_ac_i),
    .mode_bd (safe_bd_i),
    .pin     (pin_o),
    .oe      (pin_oe_o)
  );

  assign sd_flag_o = flag_q;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmp1_flt_i,
  input logic       cmp2_flt_i,
  input logic       ext_flt_n_i,
  input logic [2:0] src_sel_i,
  input logic [1:0] safe_ac_i,
  input logic [1:0] safe_bd_i,
  input logic       auto_restart_i,
  input logic       flag_wr_i,
  input logic       flag_wdata_i,
  input logic [3:0] pin_o,
  input logic [3:0] pin_oe_o,
  input logic       sd_flag_o
);
  logic lvl_ac, lvl_bd, en_ac, en_bd;
  logic [3:0] shut_pin, shut_oe;
  logic raw_fault;

  assign lvl_ac   = (safe_ac_i == 2'b10);
  assign lvl_bd   = (safe_bd_i == 2'b10);
  assign en_ac    = (safe_ac_i[0] == 1'b0);
  assign en_bd    = (safe_bd_i[0] == 1'b0);
  assign shut_pin = {lvl_bd, lvl_ac, lvl_bd, lvl_ac};
  assign shut_oe  = {en_bd, en_ac, en_bd, en_ac};
  assign raw_fault = (src_sel_i[0] && cmp1_flt_i) || (src_sel_i[1] && cmp2_flt_i)
                  || (src_sel_i[2] && !ext_flt_n_i);

  a_r2_fault_forces_safe: assert property (@(posedge clk) disable iff (rst)
    raw_fault |-> (pin_o == shut_pin && pin_oe_o == shut_oe));

  a_r5_flag_holds_safe: assert property (@(posedge clk) disable iff (rst)
    sd_flag_o |-> (pin_o == shut_pin && pin_oe_o == shut_oe));

  a_r4_comparator_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ((src_sel_i[0] && cmp1_flt_i) || (src_sel_i[1] && cmp2_flt_i)) |=> sd_flag_o);

  a_r9_fault_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_wr_i && !flag_wdata_i && src_sel_i[1] && cmp2_flt_i) |=> sd_flag_o);

  a_r1_no_source_no_flag: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 3'b000 && !sd_flag_o && !flag_wr_i) |=> !sd_flag_o);

  a_r7_auto_clears: assert property (@(posedge clk) disable iff (rst)
    (auto_restart_i && sd_flag_o && src_sel_i == 3'b000) |=> !sd_flag_o);

  a_r8_no_resume_on_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_flag_o) |-> (pin_o == shut_pin && pin_oe_o == shut_oe));
endmodule

bind pwm_fault_guard pfg_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmp1_flt_i     (cmp1_flt_i),
  .cmp2_flt_i     (cmp2_flt_i),
  .ext_flt_n_i    (ext_flt_n_i),
  .src_sel_i      (src_sel_i),
  .safe_ac_i      (safe_ac_i),
  .safe_bd_i      (safe_bd_i),
  .auto_restart_i (auto_restart_i),
  .flag_wr_i      (flag_wr_i),
  .flag_wdata_i   (flag_wdata_i),
  .pin_o          (pin_o),
  .pin_oe_o       (pin_oe_o),
  .sd_flag_o      (sd_flag_o)
);

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/100ps
module sim_pwm_fault_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp1 = 0, cmp2 = 0, extn = 1, ps = 0, autor = 0, wr = 0, wd = 0;
  logic [3:0] raw = 4'h0;
  logic [2:0] sel = 3'b111;
  logic [1:0] sac = 2'b00, sbd = 2'b00;
  logic [3:0] pin, oe;
  logic flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_fault_guard u0 (
    .clk(clk), .rst(rst), .cmp1_flt_i(cmp1), .cmp2_flt_i(cmp2), .ext_flt_n_i(extn),
    .period_start_i(ps), .pwm_raw_i(raw), .src_sel_i(sel), .safe_ac_i(sac),
    .safe_bd_i(sbd), .auto_restart_i(autor), .flag_wr_i(wr), .flag_wdata_i(wd),
    .pin_o(pin), .pin_oe_o(oe), .sd_flag_o(flag)
  );

  // behavioural reference: sync queue, sticky flag, period decision
  bit sq[$];
  bit m_flag = 0, m_run = 0;

  initial begin sq.push_back(0); sq.push_back(0); end

  always @(posedge clk) begin
    bit fs;
    fs = (sel[0] && cmp1) || (sel[1] && cmp2) || (sel[2] && sq[0]);
    if (rst) begin
      sq.delete(); sq.push_back(0); sq.push_back(0);
      m_flag <= 0; m_run <= 0;
    end else begin
      void'(sq.pop_front());
      sq.push_back(!extn);
      if (ps) m_run <= !m_flag;
      else if (m_flag) m_run <= 0;
      if (fs) m_flag <= 1;
      else if (autor) m_flag <= 0;
      else if (wr) m_flag <= wd;
    end
  end

  function automatic void model_pins(output logic [3:0] ep, output logic [3:0] eo);
    bit fr, go;
    fr = (sel[0] && cmp1) || (sel[1] && cmp2) || (sel[2] && !extn);
    go = m_run && !m_flag && !fr;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] m;
      m = (i % 2 == 0) ? sac : sbd;
      ep[i] = go ? raw[i] : (m == 2'b10);
      eo[i] = go ? 1'b1 : !m[0];
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [3:0] ep, eo;
    model_pins(ep, eo);
    check("R2 pins vs model", 32'(pin), 32'(ep));
    check("R3 enables vs model", 32'(oe), 32'(eo));
    check("R4 flag vs model", 32'(flag), 32'(m_flag));
  endtask

  // called at a negedge after inputs are set; returns at the next negedge
  task automatic step();
    #1 compare_model();
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    @(negedge clk);
    raw = 4'hF;
    steps(3);
    rst = 0;
    #0.5;
    check("R10 flag after reset", 32'(flag), 0);
    check("R10 pins safe after reset", 32'(pin), 32'h0);
    check("R10 enables after reset", 32'(oe), 32'hF);
    step();

    ps = 1; step(); ps = 0;
    raw = 4'b1010; #0.5;
    check("R8 pass after period start", 32'(pin), 32'b1010);
    check("R3 enables outside shutdown", 32'(oe), 32'hF);
    step();
    raw = 4'b0101; #0.5;
    check("R8 pass second pattern", 32'(pin), 32'b0101);
    step();

    sac = 2'b10; sbd = 2'b01; raw = 4'hF;
    cmp1 = 1; #0.5;
    check("R2 immediate force", 32'(pin), 32'b0101);
    check("R3 high and released", 32'(oe), 32'b0101);
    step();
    check("R4 flag set next edge", 32'(flag), 1);

    wr = 1; wd = 0; step(); wr = 0;
    check("R6 write ignored under fault", 32'(flag), 1);

    cmp1 = 0; steps(2);
    check("R5 flag sticky", 32'(flag), 1);
    check("R5 pins safe while set", 32'(pin), 32'b0101);
    wr = 1; wd = 0; step(); wr = 0;
    check("R5 firmware clear", 32'(flag), 0);
    check("R8 no mid-period resume", 32'(oe), 32'b0101);
    step();
    ps = 1; step(); ps = 0;
    check("R8 resume at period start", 32'(pin), 32'hF);

    cmp2 = 1; step(); cmp2 = 0; step();
    wr = 1; wd = 0; cmp2 = 1; step(); wr = 0; cmp2 = 0;
    check("R9 fault beats clear", 32'(flag), 1);
    wr = 1; step(); wr = 0;
    check("R5 clear after fault gone", 32'(flag), 0);

    autor = 1; ps = 1; step(); ps = 0;
    extn = 0; #0.5;
    check("R2 external pin immediate", 32'(oe), 32'b0101);
    step();
    check("R4 sync edge 1", 32'(flag), 0);
    step();
    check("R4 sync edge 2", 32'(flag), 0);
    step();
    check("R4 sync edge 3", 32'(flag), 1);
    extn = 1; steps(2);
    check("R7 held while sync drains", 32'(flag), 1);
    step();
    check("R7 auto clear", 32'(flag), 0);
    check("R8 safe until next period", 32'(oe), 32'b0101);
    ps = 1; step(); ps = 0;
    check("R8 resume after auto clear", 32'(oe), 32'hF);

    autor = 0;
    cmp1 = 1; step(); cmp1 = 0;
    ps = 1; step(); ps = 0;
    wr = 1; wd = 0; step(); wr = 0;
    steps(3);
    check("R8 held whole period", 32'(oe), 32'b0101);
    ps = 1; step(); ps = 0;
    check("R8 next period runs", 32'(oe), 32'hF);

    sel = 3'b000; cmp1 = 1; cmp2 = 1; extn = 0; #0.5;
    check("R1 none selected pass", 32'(pin), 32'hF);
    steps(4);
    check("R1 none selected no flag", 32'(flag), 0);
    sel = 3'b010; cmp2 = 0; steps(4);
    check("R1 unselected sources ignored", 32'(flag), 0);
    check("R1 pins pass", 32'(oe), 32'hF);
    cmp1 = 0; extn = 1; sel = 3'b111;

    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cmp1  = (lf[3:0] == 4'h0);
        cmp2  = (lf[7:4] == 4'h1);
        extn  = !(lf[11:8] == 4'h2 || lf[11:8] == 4'h3);
        ps    = (lf[14:12] == 3'b101);
        wr    = lf[2] & lf[9];
        wd    = lf[5] & lf[6] & lf[15];
        raw   = lf[13:10];
        if (n % 200 == 0) begin
          sel = lf[2:0]; sac = lf[5:4]; sbd = lf[7:6]; autor = lf[8];
        end
        step();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule